// File: doc/BRIEF.md
# Non-Arithmetic Double-to-Single Bit Converter

This block turns a 64-bit IEEE-754 double-precision operand into a 32-bit single-precision bit pattern as a pure field manipulation. It does no arithmetic on the value. It does not round: surplus fraction bits are dropped. It never quiets a NaN and it raises no flags. Operands whose exponent lies below the single-precision normal range are denormalized by a right shift toward the smallest single exponent. Exponents above the single range are not saturated: their bits are packed as they are.

A valid-qualified operand is captured and converted in one registered stage. The 32-bit result is replicated into every 32-bit word of the output. A parameter can instead select a combinational pass-through variant, in which valid and data leave in the same cycle.

Top module: `dp2sp_ns_conv`

## Requirements
- R1: The sign is input bit 63, the exponent is input bits 62:52 and the fraction is input bits 51:0. For a normal operand, output bit 31 is the sign, bit 30 is exponent bit 10, bits 29:23 are exponent bits 6:0, and bits 22:0 are fraction bits 51:29.
- R2: The conversion never rounds. Input fraction bits 28:0 have no effect on the result.
- R3: A NaN input (exponent all ones, fraction nonzero) keeps its payload top bits. Output bit 22 equals input bit 51, so a signaling NaN stays signaling. An infinity stays an infinity.
- R4: A double denormal (exponent 0, fraction nonzero) is treated as exponent 1 with the implicit bit cleared. It therefore yields a signed zero.
- R5: When the working exponent is below 897 and the working fraction (implicit bit at position 52) is nonzero, the fraction is shifted right by 897 minus the exponent and the exponent becomes 896. The output exponent field then reads 0.
- R6: A shift amount above 63 zeroes the fraction. A zero input of either sign produces a zero with the same sign.
- R7: Exponents above the single range wrap. The output exponent field is exponent bit 10 followed by exponent bits 6:0, with no clamp to infinity.
- R8: Each 32-bit word of the 64-bit output holds the same single-precision result.
- R9: out_valid rises exactly one clock after in_valid. out_data changes only on a cycle that has in_valid and holds otherwise.
- R10: A synchronous active-high reset clears out_valid and out_data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand qualifier |
| in_data | input | 64 | Double-precision operand |
| out_valid | output | 1 | Result qualifier, one cycle after in_valid |
| out_data | output | 64 | Single-precision result replicated in both words |

## Verification
Two functions can act on the same operand in the same cycle. A double denormal triggers the exponent/implicit-bit override, and the override's output then feeds the tiny-operand shift. The bench provokes this with denormals of both signs and with operands just below, at and above the 897 threshold. It judges the results against hand-derived constants and an independent bit-level model. Back-to-back valid operands also overlap the capture of a new result with the presentation of the previous one; the bench checks each result in its own cycle.

// File: rtl/dp2sp_pkg.sv
package dp2sp_pkg;
   localparam int D_EXP_W   = 11;
   localparam int D_FRAC_W  = 52;
   localparam int S_EXP_W   = 8;
   localparam int S_FRAC_W  = 23;
   localparam int D_WORD_W  = 1 + D_EXP_W + D_FRAC_W;
   localparam int S_WORD_W  = 1 + S_EXP_W + S_FRAC_W;

   function automatic int bias_of(input int ew);
      return (2 ** (ew - 1)) - 1;
   endfunction
endpackage

// File: rtl/dp2sp_unpack.sv
module dp2sp_unpack #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int TOP   = EXP_W + FRAC_W
) (
   input  logic [TOP:0]      op_i,
   output logic              sign_o,
   output logic [EXP_W-1:0]  exp_o,
   output logic [FRAC_W:0]   frac_o
);
   logic [EXP_W-1:0]  raw_exp;
   logic [FRAC_W-1:0] raw_frac;

   assign raw_exp  = op_i[TOP-1:FRAC_W];
   assign raw_frac = op_i[FRAC_W-1:0];
   assign sign_o   = op_i[TOP];

   always_comb begin
      if (raw_exp == '0 && raw_frac != '0) begin
         // subnormal source: smallest exponent, no hidden one
         exp_o  = EXP_W'(1);
         frac_o = {1'b0, raw_frac};
      end else begin
         exp_o  = raw_exp;
         frac_o = {1'b1, raw_frac};
      end
   end
endmodule

// File: rtl/dp2sp_tiny.sv
module dp2sp_tiny #(
   parameter int EXP_W     = 11,
   parameter int FRAC_W    = 52,
   parameter int TINY_LIM  = 897,
   parameter int SHIFT_CAP = 63
) (
   input  logic [EXP_W-1:0] exp_i,
   input  logic [FRAC_W:0]  frac_i,
   output logic [EXP_W-1:0] exp_o,
   output logic [FRAC_W:0]  frac_o
);
   localparam logic [EXP_W-1:0] LIM_V  = EXP_W'(TINY_LIM);
   localparam logic [EXP_W-1:0] FLOOR  = EXP_W'(TINY_LIM - 1);
   localparam logic [EXP_W-1:0] CAP_V  = EXP_W'(SHIFT_CAP);

   logic [EXP_W-1:0] shamt;

   always_comb begin
      shamt  = '0;
      exp_o  = exp_i;
      frac_o = frac_i;
      if (exp_i < LIM_V && frac_i != '0) begin
         shamt  = LIM_V - exp_i;
         frac_o = (shamt > CAP_V) ? '0 : (frac_i >> shamt);
         exp_o  = FLOOR;
      end
   end
endmodule

// File: rtl/dp2sp_pack.sv
module dp2sp_pack #(
   parameter int EXP_W    = 11,
   parameter int FRAC_W   = 52,
   parameter int S_EXP_W  = 8,
   parameter int S_FRAC_W = 23,
   parameter int OUT_W    = 64,
   localparam int SP_W    = 1 + S_EXP_W + S_FRAC_W,
   localparam int COPIES  = OUT_W / SP_W,
   localparam int DROP_W  = FRAC_W - S_FRAC_W
) (
   input  logic              sign_i,
   input  logic [EXP_W-1:0]  exp_i,
   input  logic [FRAC_W:0]   frac_i,
   output logic [OUT_W-1:0]  word_o
);
   logic [SP_W-1:0] sp;
   logic            unused_bits;

   assign sp = {sign_i, exp_i[EXP_W-1], exp_i[S_EXP_W-2:0],
                frac_i[FRAC_W-1 -: S_FRAC_W]};
   // truncated fraction and middle exponent bits are intentionally dropped
   assign unused_bits = ^{frac_i[FRAC_W], frac_i[DROP_W-1:0],
                          exp_i[EXP_W-2:S_EXP_W-1]};

   if (OUT_W % SP_W != 0) begin : g_bad_width
      $error("OUT_W must be a multiple of the single word width");
   end

   for (genvar k = 0; k < COPIES; k++) begin : g_copy
      assign word_o[k*SP_W +: SP_W] = sp;
   end
endmodule

// File: rtl/dp2sp_ns_conv.sv
module dp2sp_ns_conv
   import dp2sp_pkg::*;
#(
   parameter int  EXP_W     = D_EXP_W,
   parameter int  FRAC_W    = D_FRAC_W,
   parameter int  SEXP_W    = S_EXP_W,
   parameter int  SFRAC_W   = S_FRAC_W,
   parameter int  OUT_W     = 64,
   parameter int  SHIFT_CAP = 63,
   parameter bit  OUT_REG   = 1'b1,
   localparam int IN_W      = 1 + EXP_W + FRAC_W,
   localparam int TINY_LIM  = bias_of(EXP_W) - bias_of(SEXP_W) + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data
);
   if (SEXP_W >= EXP_W || SFRAC_W >= FRAC_W) begin : g_bad_fmt
      $error("single format must be narrower than the source format");
   end

   logic              w_sign;
   logic [EXP_W-1:0]  w_exp, t_exp;
   logic [FRAC_W:0]   w_frac, t_frac;
   logic [OUT_W-1:0]  conv;

   dp2sp_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
      .op_i(in_data), .sign_o(w_sign), .exp_o(w_exp), .frac_o(w_frac));

   dp2sp_tiny #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .TINY_LIM(TINY_LIM),
                .SHIFT_CAP(SHIFT_CAP)) u_tiny (
      .exp_i(w_exp), .frac_i(w_frac), .exp_o(t_exp), .frac_o(t_frac));

   dp2sp_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .S_EXP_W(SEXP_W),
                .S_FRAC_W(SFRAC_W), .OUT_W(OUT_W)) u_pack (
      .sign_i(w_sign), .exp_i(t_exp), .frac_i(t_frac), .word_o(conv));

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= conv;
         end
      end

      assert_valid_rise_R9: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> out_valid);
      assert_valid_fall_R9: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> !out_valid);
      assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> $stable(out_data));
      assert_sign_R1: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> out_data[31] == $past(in_data[IN_W-1]));
      assert_nan_kind_R3: assert property (@(posedge clk) disable iff (rst)
         (in_valid && in_data[IN_W-2:FRAC_W] == '1)
         |=> (out_data[30:23] == 8'hFF && out_data[22] == $past(in_data[FRAC_W-1])));
      assert_zero_R6: assert property (@(posedge clk) disable iff (rst)
         (in_valid && in_data[IN_W-2:0] == '0) |=> out_data[30:0] == '0);
      assert_words_R8: assert property (@(posedge clk) disable iff (rst)
         out_valid |-> out_data[OUT_W-1 -: 32] == out_data[31:0]);
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst;
      assign out_valid  = in_valid;
      assign out_data   = conv;
   end
endmodule

// File: tb/dp2sp_ns_conv_test.sv
module dp2sp_ns_conv_test;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [63:0] in_data;
   logic        out_valid;
   logic [63:0] out_data;
   int          checks = 0;
   int          errors = 0;
   bit          done   = 0;

   always #2.5 clk = ~clk;

   dp2sp_ns_conv uut (.clk(clk), .rst(rst), .in_valid(in_valid),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

   function automatic logic [63:0] model(input logic [63:0] x);
      logic        s;
      logic [10:0] e;
      logic [63:0] f;
      int          sh;
      logic [31:0] r;
      s = x[63];
      e = x[62:52];
      f = {11'b0, 1'b1, x[51:0]};
      if (e == 0 && x[51:0] != 0) begin e = 11'd1; f[52] = 1'b0; end
      if (e < 11'd897 && f != 0) begin
         sh = 897 - int'(e);
         if (sh > 63) f = 0; else f = f >> sh;
         e = 11'd896;
      end
      r = {s, e[10], e[6:0], f[51:29]};
      return {r, r};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive at a negedge, check at the following negedge
   task automatic send(input string req, input logic [63:0] x, input logic [31:0] exp32);
      in_data  = x;
      in_valid = 1'b1;
      @(negedge clk);
      chk({req, " valid"}, {63'b0, out_valid}, 64'd1);
      chk(req, out_data, {exp32, exp32});
      chk({req, " model"}, out_data, model(x));
      in_valid = 1'b0;
   endtask

   task automatic t_reset();
      rst = 1'b1; in_valid = 1'b0; in_data = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk("R10 reset valid", {63'b0, out_valid}, 64'd0);
      chk("R10 reset data", out_data, 64'd0);
   endtask

   task automatic t_normal();
      send("R1 one", 64'h3FF0_0000_0000_0000, 32'h3F80_0000);
      send("R1 neg2p5", 64'hC004_0000_0000_0000, 32'hC020_0000);
      send("R8 words", 64'h4009_21FB_5444_2D18, model(64'h4009_21FB_5444_2D18)
           >> 32);
   endtask

   task automatic t_trunc();
      send("R2 trunc", 64'h3FF0_0000_1FFF_FFFF, 32'h3F80_0000);
      send("R2 trunc2", 64'h3FF0_0000_3FFF_FFFF, 32'h3F80_0001);
   endtask

   task automatic t_nan();
      send("R3 snan", 64'h7FF4_0000_0000_0000, 32'h7FA0_0000);
      send("R3 qnan", 64'hFFF8_0000_0000_0000, 32'hFFC0_0000);
      send("R3 inf", 64'h7FF0_0000_0000_0000, 32'h7F80_0000);
   endtask

   task automatic t_denorm();
      send("R4 denorm", 64'h000F_FFFF_FFFF_FFFF, 32'h0000_0000);
      send("R4 neg denorm", 64'h8000_0000_0000_0001, 32'h8000_0000);
   endtask

   task automatic t_tiny();
      send("R5 smallest", 64'h36A0_0000_0000_0000, 32'h0000_0001);
      send("R5 exp896", 64'h3800_0000_0000_0000, 32'h0040_0000);
      send("R5 exp897", 64'h3810_0000_0000_0000, 32'h0080_0000);
      send("R5 exp860", 64'h35C0_0000_0000_0000, model(64'h35C0_0000_0000_0000) >> 32);
   endtask

   task automatic t_zero();
      send("R6 pos zero", 64'h0000_0000_0000_0000, 32'h0000_0000);
      send("R6 neg zero", 64'h8000_0000_0000_0000, 32'h8000_0000);
      send("R6 cap", 64'h3420_0000_0000_0000, 32'h0000_0000);
   endtask

   task automatic t_wrap();
      send("R7 exp1151", 64'h47F0_0000_0000_0000, 32'h7F80_0000);
      send("R7 exp1200", 64'h4B00_0000_0000_0000, 32'h5800_0000);
   endtask

   task automatic t_hold();
      logic [63:0] kept;
      send("R9 load", 64'h3FF8_0000_0000_0000, 32'h3FC0_0000);
      kept = out_data;
      in_data = 64'hDEAD_BEEF_0123_4567;
      @(negedge clk);
      chk("R9 drop valid", {63'b0, out_valid}, 64'd0);
      @(negedge clk);
      chk("R9 hold data", out_data, kept);
   endtask

   task automatic t_stream();
      for (int i = 0; i < 16; i++) begin
         logic [63:0] x;
         x = {i[0], 11'(860 + i * 25), 52'h8_1234_5678_9ABC ^ 52'(i * 7919)};
         send("R9 stream", x, model(x) >> 32);
      end
   endtask

   initial begin
      t_reset();
      t_normal();
      t_trunc();
      t_nan();
      t_denorm();
      t_tiny();
      t_zero();
      t_wrap();
      t_hold();
      t_stream();
      @(negedge clk);
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule